// File: doc/BRIEF.md
# Multi-Mode Display Host Bus Front End

This block is the host-facing port of a display controller. A host moves command and data bytes across one shared set of pins, which act as an 8-bit parallel bus, a 4-bit bus carrying each byte as two nibbles, or a bit-serial link. Straps pick the format. A low-active strobe frames every access. A single enable/shift-clock pin times each transfer: input is taken on its rising edge and output is launched on its falling edge.

All pins are brought into the system clock domain through a two-stage synchronizer. Edges of the shared clock pin are then detected there. Each completed received byte is placed on an internal write port as a single-cycle valid pulse. For reads, the block takes a byte from an internal read port and drives it back on the same data lines. It drives only the lanes that the active format uses, and only while the strobe is low and the read direction is selected. The format is sampled once when reset is released and then held for the rest of operation.

Top module: `hostbus_front`

## Requirements
- R1: Format decode at the first clock after reset release: strap_wide high selects 8-bit parallel. strap_wide low with bus_din[7] high selects 4-bit parallel. Both low selects serial. While reading, the format shows in bus_oe: 8'hFF for 8-bit, 8'h0F for 4-bit, 8'h01 for serial.
- R2: After the format is latched, changes on strap_wide or bus_din[7] have no effect on the format.
- R3: In 8-bit mode, a rising edge of bus_sck while bus_cs_n is low and bus_rd is low captures bus_din as one complete byte.
- R4: In 4-bit mode, a byte arrives on bus_din[3:0] as two rising edges, upper nibble first. The byte completes on the second edge.
- R5: In serial mode, a byte arrives on bus_din[0], most significant bit first. It completes on the eighth rising edge within one strobe-low window.
- R6: Taking bus_cs_n high discards a partially received byte. The next window starts again at the upper nibble or the first bit.
- R7: Rising edges of bus_sck while bus_cs_n is high produce no received byte.
- R8: Each completed byte gives exactly one wr_valid pulse, one clock wide, with the byte on wr_byte. wr_valid is low after reset.
- R9: In 8-bit mode, reading drives rd_byte onto bus_dout on each falling edge of bus_sck. bus_dout is zero after reset.
- R10: In 4-bit mode, reading drives the upper nibble of rd_byte onto bus_dout[3:0] on the first falling edge and the lower nibble on the second.
- R11: In serial mode, reading drives rd_byte onto bus_dout[0], most significant bit first, one bit per falling edge.
- R12: bus_oe is all zero after reset, while bus_cs_n is high, and while bus_rd is low.
- R13: Taking bus_cs_n high restarts the read sequence, so the next window begins with the upper nibble or the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_wide | input | 1 | Format strap; high selects the 8-bit bus |
| bus_sck | input | 1 | Shared enable / shift clock from the host |
| bus_cs_n | input | 1 | Access strobe, active low |
| bus_rd | input | 1 | Direction: high = host reads, low = host writes |
| bus_din | input | BYTE_W | Data lines as seen from the pins; bit BYTE_W-1 also serves as the nibble-mode strap |
| rd_byte | input | BYTE_W | Internal read port: byte to return to the host |
| bus_dout | output | BYTE_W | Data driven toward the pins |
| bus_oe | output | BYTE_W | Per-lane output enable for bus_dout |
| wr_valid | output | 1 | One-cycle pulse marking a completed received byte |
| wr_byte | output | BYTE_W | Received byte, valid with wr_valid |

## Verification
The bench builds the block with BYTE_W = 8 and SYNC_STAGES = 2. At these values every format can be run end to end: a full byte, both nibble beats and all eight serial bits. The stimulus table resets the block into each format and then writes and reads back a byte. Directed cases cover the ordering rules: partial bytes cut off by the strobe, edges outside the window, straps moving after the latch, and a read restart.

// File: rtl/hostbus_pkg.sv
// Package: shared types for the multi-mode host bus front end.
// Assumes: the format is decoded from two static straps.
package hostbus_pkg;

    typedef enum logic [1:0] {
        BUS_PAR8 = 2'd0,
        BUS_PAR4 = 2'd1,
        BUS_SER  = 2'd2
    } bus_fmt_e;

    // Maps the two strap levels onto a bus format.
    function automatic bus_fmt_e decode_straps(input logic wide, input logic nib);
        if (wide)
            return BUS_PAR8;
        else if (nib)
            return BUS_PAR4;
        else
            return BUS_SER;
    endfunction

endpackage

// File: rtl/hostbus_sync.sv
// Module: hostbus_sync
// A chain of STAGES flops per bit. It brings asynchronous pin levels into the clk domain.
// Assumes: each bit is a slow level; no bus coherency is implied across bits.
module hostbus_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                // First stage samples the raw pin level.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Later stages pass the level down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[gi] <= RST_VAL;
                    else        stg[gi] <= stg[gi-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/hostbus_fmt_latch.sv
// Module: hostbus_fmt_latch
// Samples the format straps on the first clock after reset release and holds them afterwards.
// Assumes: the straps are stable around reset release. They are taken straight from the pins.
module hostbus_fmt_latch
    import hostbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     strap_wide,
    input  logic     strap_nib,
    output bus_fmt_e fmt,
    output logic     locked
);

    // Capture the strap decode once, then freeze it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt    <= BUS_PAR8;
            locked <= 1'b0;
        end else if (!locked) begin
            fmt    <= decode_straps(strap_wide, strap_nib);
            locked <= 1'b1;
        end
    end

    // R2
    fmt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(fmt)));

endmodule

// File: rtl/hostbus_rx.sv
// Module: hostbus_rx
// Assembles host write bytes in whichever format is latched. It pulses wr_valid per byte.
// Assumes: edge_rise and din come from synchronizers with equal latency.
module hostbus_rx
    import hostbus_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  bus_fmt_e          fmt,
    input  logic              win_open,
    input  logic              dir_rd,
    input  logic              edge_rise,
    input  logic [BYTE_W-1:0] din,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_byte
);

    localparam int HALF_W = BYTE_W / 2;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              half_seen;
    logic [HALF_W-1:0] upper_q;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;

    // Receive state machine: gather nibbles or bits and emit complete bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid  <= 1'b0;
            wr_byte   <= '0;
            half_seen <= 1'b0;
            upper_q   <= '0;
            shreg     <= '0;
            bit_cnt   <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (!win_open) begin
                half_seen <= 1'b0;
                bit_cnt   <= '0;
            end else if (locked && !dir_rd && edge_rise) begin
                case (fmt)
                    BUS_PAR8: begin
                        wr_byte  <= din;
                        wr_valid <= 1'b1;
                    end
                    BUS_PAR4: begin
                        if (!half_seen) begin
                            upper_q   <= din[HALF_W-1:0];
                            half_seen <= 1'b1;
                        end else begin
                            wr_byte   <= {upper_q, din[HALF_W-1:0]};
                            wr_valid  <= 1'b1;
                            half_seen <= 1'b0;
                        end
                    end
                    default: begin
                        shreg <= {shreg[BYTE_W-2:0], din[0]};
                        if (bit_cnt == LAST_BIT) begin
                            wr_byte  <= {shreg[BYTE_W-2:0], din[0]};
                            wr_valid <= 1'b1;
                            bit_cnt  <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R7
    valid_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(win_open));

endmodule

// File: rtl/hostbus_tx.sv
// Module: hostbus_tx
// Launches read data on falling edges of the shared clock in the latched format, and drives the lane enables.
// Assumes: rd_byte is held steady by the core for the whole strobe window.
module hostbus_tx
    import hostbus_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  bus_fmt_e          fmt,
    input  logic              win_open,
    input  logic              dir_rd,
    input  logic              edge_fall,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] dq_out,
    output logic [BYTE_W-1:0] dq_oe
);

    localparam int HALF_W = BYTE_W / 2;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic              tx_half;
    logic [CNT_W-1:0]  tx_cnt;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] lane_mask;

    // Output launch: a byte, a nibble or a bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out  <= '0;
            tx_half <= 1'b0;
            tx_cnt  <= '0;
            tx_sh   <= '0;
        end else if (!win_open) begin
            tx_half <= 1'b0;
            tx_cnt  <= '0;
        end else if (locked && dir_rd && edge_fall) begin
            case (fmt)
                BUS_PAR8: dq_out <= rd_byte;
                BUS_PAR4: begin
                    dq_out  <= {{(BYTE_W-HALF_W){1'b0}},
                                tx_half ? rd_byte[HALF_W-1:0] : rd_byte[BYTE_W-1:HALF_W]};
                    tx_half <= ~tx_half;
                end
                default: begin
                    if (tx_cnt == '0) begin
                        dq_out <= {{(BYTE_W-1){1'b0}}, rd_byte[BYTE_W-1]};
                        tx_sh  <= {rd_byte[BYTE_W-2:0], 1'b0};
                    end else begin
                        dq_out <= {{(BYTE_W-1){1'b0}}, tx_sh[BYTE_W-1]};
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                    end
                    tx_cnt <= (tx_cnt == LAST_BIT) ? '0 : tx_cnt + 1'b1;
                end
            endcase
        end
    end

    // Lane enables: only the lanes of the active format, only during a read window.
    always_comb begin
        lane_mask = '0;
        case (fmt)
            BUS_PAR8: lane_mask = '1;
            BUS_PAR4: lane_mask[HALF_W-1:0] = '1;
            default:  lane_mask[0] = 1'b1;
        endcase
        dq_oe = (locked && win_open && dir_rd) ? lane_mask : '0;
    end

    // R9
    out_on_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_fall |=> $stable(dq_out));

endmodule

// File: rtl/hostbus_front.sv
// Module: hostbus_front (top)
// Host bus front end. It synchronizes the pins, finds edges of the shared clock pin,
// latches the format, and hands bytes between the pins and the internal write/read ports.
// Assumes: bus_sck high and low phases each last well over SYNC_STAGES+1 clk periods.
module hostbus_front
    import hostbus_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_wide,
    input  logic              bus_sck,
    input  logic              bus_cs_n,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_din,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] bus_dout,
    output logic [BYTE_W-1:0] bus_oe,
    output logic              wr_valid,
    output logic [BYTE_W-1:0] wr_byte
);

    localparam int CTL_W = 3;

    logic [CTL_W-1:0]  ctl_s;
    logic [BYTE_W-1:0] din_s;
    logic              sck_s, cs_n_s, rd_s;
    logic              sck_prev;
    logic              edge_rise, edge_fall;
    bus_fmt_e          fmt;
    logic              locked;

    hostbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_sck, bus_cs_n, bus_rd}),
        .q     (ctl_s)
    );

    hostbus_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_din),
        .q     (din_s)
    );

    assign sck_s  = ctl_s[2];
    assign cs_n_s = ctl_s[1];
    assign rd_s   = ctl_s[0];

    // Previous synchronized clock-pin level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    assign edge_rise = sck_s & ~sck_prev;
    assign edge_fall = ~sck_s & sck_prev;

    hostbus_fmt_latch u_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_wide (strap_wide),
        .strap_nib  (bus_din[BYTE_W-1]),
        .fmt        (fmt),
        .locked     (locked)
    );

    hostbus_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .locked    (locked),
        .fmt       (fmt),
        .win_open  (~cs_n_s),
        .dir_rd    (rd_s),
        .edge_rise (edge_rise),
        .din       (din_s),
        .wr_valid  (wr_valid),
        .wr_byte   (wr_byte)
    );

    hostbus_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .locked    (locked),
        .fmt       (fmt),
        .win_open  (~cs_n_s),
        .dir_rd    (rd_s),
        .edge_fall (edge_fall),
        .rd_byte   (rd_byte),
        .dq_out    (bus_dout),
        .dq_oe     (bus_oe)
    );

    // R12
    no_drive_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_cs_n, SYNC_STAGES) |-> (bus_oe == '0));

endmodule

// File: tb/sim_hostbus_front.sv
module sim_hostbus_front;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_wide = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] rd_byte = 8'h00;
    logic [7:0] dout, oe, wr_byte;
    logic       wr_valid;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int doubles = 0;
    logic [7:0] last_byte = 8'h00;
    logic prev_valid = 1'b0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    hostbus_front #(.BYTE_W(8), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .strap_wide(strap_wide), .bus_sck(sck),
        .bus_cs_n(cs_n), .bus_rd(rd), .bus_din(din), .rd_byte(rd_byte),
        .bus_dout(dout), .bus_oe(oe), .wr_valid(wr_valid), .wr_byte(wr_byte)
    );

    // Write-port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (wr_valid) begin
            pulses++;
            last_byte = wr_byte;
            if (prev_valid) doubles++;
        end
        prev_valid = wr_valid;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_pulse();
        sck = 1'b1; wait_clk(4);
        sck = 1'b0; wait_clk(4);
    endtask

    // Mode code: 0 = 8-bit, 1 = 4-bit, 2 = serial.
    task automatic do_reset(input logic [1:0] m);
        strap_wide = (m == 2'd0);
        din = (m == 2'd1) ? 8'h80 : 8'h00;
        cs_n = 1'b1; rd = 1'b0; sck = 1'b0;
        rst_n = 1'b0; wait_clk(3);
        rst_n = 1'b1; wait_clk(3);
    endtask

    function automatic int beats(input logic [1:0] m);
        return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 8;
    endfunction

    function automatic logic [7:0] lane_mask(input logic [1:0] m);
        return (m == 2'd0) ? 8'hFF : (m == 2'd1) ? 8'h0F : 8'h01;
    endfunction

    task automatic open_w(input logic dir);
        rd = dir; cs_n = 1'b0; wait_clk(4);
    endtask

    task automatic close_w();
        wait_clk(4); cs_n = 1'b1; wait_clk(5);
    endtask

    task automatic send_beats(input logic [1:0] m, input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            case (m)
                2'd0:    din = b;
                2'd1:    din = (i == 0) ? {4'h0, b[7:4]} : {4'h0, b[3:0]};
                default: din = {7'h00, b[7-i]};
            endcase
            wait_clk(1);
            sck_pulse();
        end
    endtask

    task automatic recv_beats(input logic [1:0] m, input int n, output logic [7:0] got);
        got = 8'h00;
        for (int i = 0; i < n; i++) begin
            sck_pulse();
            wait_clk(1);
            case (m)
                2'd0:    got = dout;
                2'd1:    got = {got[3:0], dout[3:0]};
                default: got = {got[6:0], dout[0]};
            endcase
        end
    endtask

    localparam logic [9:0] VEC [6] = '{
        {2'd0, 8'hA5}, {2'd1, 8'h3C}, {2'd2, 8'h96},
        {2'd0, 8'h00}, {2'd1, 8'hFF}, {2'd2, 8'h01}
    };

    initial begin
        logic [7:0] got;
        int p0;

        // Reset state
        do_reset(2'd0);
        chk("R12", oe, 8'h00);
        chk("R8", wr_valid, 1'b0);
        chk("R9", dout, 8'h00);

        // Table: write then read back in each format
        for (int k = 0; k < 6; k++) begin
            logic [1:0] m;
            logic [7:0] b;
            string wtag, rtag;
            m = VEC[k][9:8];
            b = VEC[k][7:0];
            wtag = (m == 2'd0) ? "R3" : (m == 2'd1) ? "R4" : "R5";
            rtag = (m == 2'd0) ? "R9" : (m == 2'd1) ? "R10" : "R11";
            do_reset(m);
            p0 = pulses;
            open_w(1'b0);
            send_beats(m, b, beats(m));
            close_w();
            chk(wtag, pulses - p0, 1);
            chk(wtag, last_byte, b);
            rd_byte = b;
            open_w(1'b1);
            chk("R1", oe, lane_mask(m));
            recv_beats(m, beats(m), got);
            chk(rtag, got, b);
            close_w();
            chk("R12", oe, 8'h00);
        end

        // R2: straps moved after the latch
        do_reset(2'd0);
        strap_wide = 1'b0; din = 8'h00; wait_clk(3);
        p0 = pulses;
        open_w(1'b0);
        send_beats(2'd0, 8'h5A, 1);
        close_w();
        chk("R2", pulses - p0, 1);
        chk("R2", last_byte, 8'h5A);

        // R6: partial nibble pair discarded
        do_reset(2'd1);
        p0 = pulses;
        open_w(1'b0); send_beats(2'd1, 8'hE7, 1); close_w();
        open_w(1'b0); send_beats(2'd1, 8'h12, 2); close_w();
        chk("R6", pulses - p0, 1);
        chk("R6", last_byte, 8'h12);

        // R6: partial serial byte discarded
        do_reset(2'd2);
        p0 = pulses;
        open_w(1'b0); send_beats(2'd2, 8'hFF, 3); close_w();
        open_w(1'b0); send_beats(2'd2, 8'h4C, 8); close_w();
        chk("R6", pulses - p0, 1);
        chk("R6", last_byte, 8'h4C);

        // R7: edges with strobe high
        do_reset(2'd0);
        p0 = pulses;
        cs_n = 1'b1; rd = 1'b0; din = 8'h33;
        sck_pulse(); sck_pulse(); wait_clk(4);
        chk("R7", pulses - p0, 0);
        do_reset(2'd2);
        p0 = pulses;
        cs_n = 1'b1;
        send_beats(2'd2, 8'hAA, 8); wait_clk(4);
        chk("R7", pulses - p0, 0);

        // R13: read sequence restarts with a new window
        do_reset(2'd1);
        rd_byte = 8'hC3;
        open_w(1'b1); recv_beats(2'd1, 1, got); close_w();
        chk("R10", got, 8'h0C);
        open_w(1'b1); recv_beats(2'd1, 1, got); close_w();
        chk("R13", got, 8'h0C);

        // R12: strobe low but write direction, and read direction with strobe high
        open_w(1'b0);
        chk("R12", oe, 8'h00);
        close_w();
        rd = 1'b1; wait_clk(4);
        chk("R12", oe, 8'h00);

        // R8: no pulse ever wider than one cycle
        chk("R8", doubles, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule